// File: doc/BRIEF.md
# Weighted Hysteresis Threshold Gate

This block is a state-holding threshold gate of the kind used to build delay-insensitive dual-rail datapaths. It has up to four single-bit inputs. Each input carries a small integer weight, and the gate has a threshold. The output goes high once the weighted count of the inputs that are high reaches the threshold. After that the output stays high until every input has dropped back to zero. This hysteresis makes the gate wait for a full return to the empty (all-low) wavefront before it can fire again.

The state-holding behaviour is modelled with an evaluation clock, so the gate stays synthesizable. On each rising edge the gate samples its inputs and updates its held output. With unit weights and a threshold equal to the input count, the gate is an n-input C-element. With a threshold of one, it is an n-input OR. A parameter selects the value that an active-low asynchronous reset forces onto the output, either 0 or 1. The gate can then seed a register stage with either a NULL value or a DATA value.

Top module: `thr_gate`

## Requirements
- R1: When the weighted sum of the high inputs is at least THRESH at a rising clock edge, q_o is 1 after that edge.
- R2: Once q_o is 1, it stays 1 across every edge at which at least one input is high, even if the weighted sum is below THRESH.
- R3: When all inputs are low at a rising edge, q_o is 0 after that edge.
- R4: While q_o is 0, an edge at which some input is high but the weighted sum is below THRESH leaves q_o at 0.
- R5: The weight of input i is the 4-bit field WEIGHTS[4i+3:4i]. With four inputs, weights 2,1,1,1 (input 0 heavy) and THRESH 3, the gate fires exactly for the input sets that contain {0,1}, {0,2}, {0,3} or {1,2,3}.
- R6: With unit weights and THRESH equal to N_IN, the gate acts as a C-element. It sets only when all inputs are high, and it clears only when all inputs are low.
- R7: With unit weights and THRESH 1, the output is 1 after any edge at which some input is high, and 0 after an edge at which all inputs are low.
- R8: While rst_ni is low, q_o equals RST_VAL whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Evaluation clock; the held state updates on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset, forces q_o to RST_VAL |
| a_i | input | N_IN | Gate inputs, one rail each |
| q_o | output | 1 | Hysteresis threshold output |

## Verification
The bench builds three instances of the gate. The first has four inputs with weights 2,1,1,1, threshold 3 and reset to 0. Its sixteen input patterns are swept from a cleared state, which compares the weighted set function against a sum computed in the bench. The same instance also runs the set-hold-release sequence. The second is a three-input C-element with reset to 1, which checks a reset value of 1 and a threshold equal to the input count. The third is a two-input OR configuration, which checks a threshold of one.

// File: rtl/thr_gate_pkg.sv
package thr_gate_pkg;
  localparam int unsigned MAX_IN = 4;
  localparam int unsigned W_BITS = 4;
  localparam int unsigned SUM_W  = $clog2(MAX_IN * ((1 << W_BITS) - 1) + 1);

  typedef logic [SUM_W-1:0] wsum_t;

  function automatic int unsigned weight_of(logic [MAX_IN*W_BITS-1:0] w, int unsigned i);
    return 32'(w[i*W_BITS +: W_BITS]);
  endfunction

  function automatic int unsigned weight_total(logic [MAX_IN*W_BITS-1:0] w, int unsigned n);
    int unsigned t;
    t = 0;
    for (int unsigned i = 0; i < n; i++) t += weight_of(w, i);
    return t;
  endfunction
endpackage

// File: rtl/thr_wsum.sv
module thr_wsum
  import thr_gate_pkg::*;
#(
  parameter int unsigned N_IN = 4,
  parameter logic [MAX_IN*W_BITS-1:0] WEIGHTS = 16'h1112
) (
  input  logic [N_IN-1:0] a_i,
  output wsum_t           sum_o
);
  wsum_t term [N_IN];

  for (genvar i = 0; i < N_IN; i++) begin : g_term
    localparam wsum_t W = SUM_W'(weight_of(WEIGHTS, i));
    assign term[i] = a_i[i] ? W : '0;
  end

  always_comb begin
    sum_o = '0;
    for (int unsigned i = 0; i < N_IN; i++) sum_o = sum_o + term[i];
  end
endmodule

// File: rtl/thr_hold.sv
module thr_hold #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/thr_gate.sv
module thr_gate
  import thr_gate_pkg::*;
#(
  parameter int unsigned N_IN = 4,
  parameter int unsigned THRESH = 3,
  parameter logic [MAX_IN*W_BITS-1:0] WEIGHTS = 16'h1112,
  parameter logic RST_VAL = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] a_i,
  output logic            q_o
);
  localparam int unsigned W_TOTAL = weight_total(WEIGHTS, N_IN);

  if (N_IN < 1 || N_IN > MAX_IN) begin : g_bad_n
    $error("thr_gate: N_IN out of range");
  end
  if (THRESH < 1 || THRESH > W_TOTAL) begin : g_bad_thr
    $error("thr_gate: THRESH out of range");
  end
  for (genvar i = 0; i < N_IN; i++) begin : g_wchk
    if (weight_of(WEIGHTS, i) == 0) begin : g_zero
      $error("thr_gate: zero weight");
    end
  end

  wsum_t sum;
  logic  set, clr;

  thr_wsum #(.N_IN(N_IN), .WEIGHTS(WEIGHTS)) u_wsum (
    .a_i   (a_i),
    .sum_o (sum)
  );

  assign set = (sum >= SUM_W'(THRESH));
  assign clr = ~|a_i;

  thr_hold #(.RST_VAL(RST_VAL)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set),
    .clr_i  (clr),
    .q_o    (q_o)
  );
endmodule

// File: rtl/thr_gate_chk.sv
module thr_gate_chk
  import thr_gate_pkg::*;
#(
  parameter int unsigned N_IN = 4,
  parameter int unsigned THRESH = 3,
  parameter logic [MAX_IN*W_BITS-1:0] WEIGHTS = 16'h1112,
  parameter logic RST_VAL = 1'b0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_IN-1:0] a_i,
  input logic            q_o
);
  int unsigned ref_sum;
  always_comb begin
    ref_sum = 0;
    for (int unsigned i = 0; i < N_IN; i++)
      if (a_i[i]) ref_sum += weight_of(WEIGHTS, i);
  end

  assert_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_sum >= THRESH) |=> q_o);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && a_i != '0) |=> q_o);
  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i == '0) |=> !q_o);
  assert_stay_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_o && a_i != '0 && ref_sum < THRESH) |=> !q_o);

  always @(negedge clk_i) begin
    if (!rst_ni) assert_reset_R8: assert (q_o == RST_VAL);
  end
endmodule

bind thr_gate thr_gate_chk #(
  .N_IN(N_IN), .THRESH(THRESH), .WEIGHTS(WEIGHTS), .RST_VAL(RST_VAL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .q_o(q_o)
);

// File: tb/sim_thr_gate.sv
module sim_thr_gate;
  localparam int unsigned CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] a0 = '0;
  logic [2:0] a1 = '0;
  logic [1:0] a2 = '0;
  logic       q0, q1, q2;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thr_gate #(.N_IN(4), .THRESH(3), .WEIGHTS(16'h1112), .RST_VAL(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a0), .q_o(q0));
  thr_gate #(.N_IN(3), .THRESH(3), .WEIGHTS(16'h0111), .RST_VAL(1'b1)) u_cel (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a1), .q_o(q1));
  thr_gate #(.N_IN(2), .THRESH(1), .WEIGHTS(16'h0011), .RST_VAL(1'b0)) u_or (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a2), .q_o(q2));

  task automatic check(string req, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // one evaluation edge, then settle at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic fires(logic [3:0] p);
    int s;
    s = 2 * int'(p[0]) + int'(p[1]) + int'(p[2]) + int'(p[3]);
    return s >= 3;
  endfunction

  task automatic t_reset();
    a0 = 4'b1111; a1 = 3'b111; a2 = 2'b11;
    step(); step();
    check("R8 u0 held at 0", q0, 1'b0);
    check("R8 u_cel held at 1", q1, 1'b1);
    check("R8 u_or held at 0", q2, 1'b0);
    a0 = '0; a1 = '0; a2 = '0;
    rst_n = 1'b1;
    step();
    check("R3 u_cel clears after release", q1, 1'b0);
    check("R3 u0 stays 0", q0, 1'b0);
  endtask

  task automatic t_weighted();
    for (int p = 0; p < 16; p++) begin
      a0 = '0; step();
      a0 = 4'(p); step();
      check($sformatf("R5/R1 pattern %04b", 4'(p)), q0, fires(4'(p)));
    end
  endtask

  task automatic t_hyst();
    a0 = '0;     step();
    a0 = 4'b0011; step(); check("R1 set on AB", q0, 1'b1);
    a0 = 4'b0010; step(); check("R2 hold below threshold", q0, 1'b1);
    a0 = 4'b0100; step(); check("R2 hold other input", q0, 1'b1);
    a0 = 4'b0000; step(); check("R3 clear on all low", q0, 1'b0);
    a0 = 4'b0100; step(); check("R4 stay low below threshold", q0, 1'b0);
    a0 = 4'b0110; step(); check("R4 stay low sum 2", q0, 1'b0);
    a0 = 4'b1110; step(); check("R1 set on BCD", q0, 1'b1);
    a0 = 4'b0000; step(); check("R3 clear again", q0, 1'b0);
  endtask

  task automatic t_celem();
    a1 = 3'b001; step(); check("R6 one of three", q1, 1'b0);
    a1 = 3'b011; step(); check("R6 two of three", q1, 1'b0);
    a1 = 3'b111; step(); check("R6 all three", q1, 1'b1);
    a1 = 3'b010; step(); check("R6 hold partial", q1, 1'b1);
    a1 = 3'b000; step(); check("R6 release", q1, 1'b0);
  endtask

  task automatic t_or();
    a2 = 2'b01; step(); check("R7 input 0", q2, 1'b1);
    a2 = 2'b00; step(); check("R7 low", q2, 1'b0);
    a2 = 2'b10; step(); check("R7 input 1", q2, 1'b1);
    a2 = 2'b11; step(); check("R7 both", q2, 1'b1);
    a2 = 2'b00; step(); check("R7 low again", q2, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_weighted();
    t_hyst();
    t_celem();
    t_or();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule